// File: doc/BRIEF.md
# Reset Line Controller with Acknowledged Status

This block drives a set of reset lines, up to 128, from a small word-wide register bus. Each line has one control bit in a bank of four writable words. A 1 holds the line in reset and a 0 releases it. The control bit is carried into the line's own clock domain through a two-flop synchronizer, and the synchronizer advances only on cycles where that line's clock enable is high. The resulting reset output is carried back into the bus clock through a second two-flop synchronizer. That returned acknowledgement is what the status words report. Software can therefore tell when a target domain has actually entered or left reset. A line whose clock is gated stays in its previous state and keeps reporting that state.

The status encoding is set per line by a parameter mask. Each mask bit gives the status value that line shows while its acknowledged state is "in reset". The opposite value is shown once the line has been released. The usual setting is 0 for in reset, with a few lines using the opposite sense. Reads have no side effects. Software may therefore access a neighbouring pair of words as the low and high halves of a 64-bit quantity, low word first.

The register bus is plain: an address, a write enable, write data and combinational read data. There is no handshake. Reads and writes complete in the cycle they are presented.

Top module: `reset_line_ctrl`

## Requirements
- R1: After power-on reset, every implemented control bit is 1, every reset output is 1, and every status bit reads its mask value.
- R2: A write to byte address 0x00, 0x04, 0x08 or 0x0C (control word m = 0..3) sets line 32*m+n from bit n of the write data: 1 holds the line in reset and 0 releases it. Reading the same address returns the stored bits.
- R3: With the target clock equal to the bus clock and its enable high, a line's reset output follows a control change two clock edges after the write edge. The status bit follows four edges after the write edge.
- R4: Status words sit at byte addresses 0x10, 0x14, 0x18 and 0x1C, one per control word. Status bit n of word m reads MASK[32*m+n] while the line is acknowledged in reset, and the inverse of that mask bit once the line is acknowledged released.
- R5: While a line's clock enable is low, its reset output and status bit hold their values even if the control bit changes. They complete the change once the enable returns high.
- R6: A write to a status address, to any address not aligned to 4 bytes, or to any address at 0x20 or above changes no control bit. A read of such an unaligned or out-of-range address returns 0.
- R7: For indices at or above NUM_LINES, the control bits read 0 and the status bits read their mask value.
- R8: Back-to-back writes to the low and high words of a pair both take effect, each on its own timing. Reads between them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset for both domains |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising bus clock |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| tgt_clk | input | NUM_LINES | Clock of each line's target domain |
| tgt_clk_en | input | NUM_LINES | Per-line enable; synchronizers advance only while it is high |
| rst_out | output | NUM_LINES | Per-line reset, high while held in reset |

## Verification
A write to one control word can land in the same cycle as the synchronizer stage of an earlier write to the neighbouring word. This collision is provoked by writing the low word and then the high word on consecutive edges. The bench then reads both status words on every following cycle and requires the low word to flip exactly four edges after its write and the high word exactly one edge later, with neither disturbing the other. The second collision puts a control change together with a gated clock: the change is held back while the enable is low and must complete once it is raised.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int MAX_LINES = NUM_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_STATUS = 2'd2
  } sel_e;

  // Bits of word w that map to an implemented line.
  function automatic word_t impl_bits(input int lines, input int w);
    word_t r;
    for (int b = 0; b < WORD_W; b++) begin
      r[b] = ((w * WORD_W + b) < lines);
    end
    return r;
  endfunction
endpackage

// File: rtl/rlc_regs.sv
module rlc_regs
  import rlc_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wr_en,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic [NUM_WORDS*WORD_W-1:0]   status_flat,
  output logic [WORD_W-1:0]             rd_data,
  output logic [NUM_WORDS*WORD_W-1:0]   ctrl_flat
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic [NUM_WORDS*WORD_W-1:0] impl_flat;

  always_comb begin
    idx = addr[IDX_W+1:2];
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00 && addr[ADDR_W-1:5] == '0) begin
      sel = addr[4] ? SEL_STATUS : SEL_CTRL;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam word_t IMPL = impl_bits(NUM_LINES, w);
    assign impl_flat[w*WORD_W +: WORD_W] = IMPL;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_flat[w*WORD_W +: WORD_W] <= IMPL;
      end else if (wr_en && sel == SEL_CTRL && idx == IDX_W'(w)) begin
        ctrl_flat[w*WORD_W +: WORD_W] <= wr_data & IMPL;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rd_data = ctrl_flat[idx*WORD_W +: WORD_W];
      SEL_STATUS: rd_data = status_flat[idx*WORD_W +: WORD_W];
      default:    rd_data = '0;
    endcase
  end

  // R1: control bank comes out of reset fully asserted
  assert_reset_all_held_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (ctrl_flat == impl_flat));

  // R2: a control write is stored in the addressed word
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_CTRL) |=>
      (ctrl_flat[$past(idx)*WORD_W +: WORD_W] ==
       ($past(wr_data) & impl_flat[$past(idx)*WORD_W +: WORD_W])));

  // R6: writes anywhere else leave the control bank untouched
  assert_ignored_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel != SEL_CTRL) |=> $stable(ctrl_flat));
endmodule

// File: rtl/rlc_line_sync.sv
module rlc_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_clk,
  input  logic tgt_en,
  input  logic req,
  output logic rst_out,
  output logic ack
);
  logic tgt_s1;
  logic ack_s1;

  // Target domain: request crosses in, advances only while enabled.
  always_ff @(posedge tgt_clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_s1  <= 1'b1;
      rst_out <= 1'b1;
    end else if (tgt_en) begin
      tgt_s1  <= req;
      rst_out <= tgt_s1;
    end
  end

  // Bus domain: the reached state crosses back as acknowledgement.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b1;
      ack    <= 1'b1;
    end else begin
      ack_s1 <= rst_out;
      ack    <= ack_s1;
    end
  end

  // R5: a gated target clock freezes the line's reset output
  assert_gated_hold_R5: assert property (@(posedge tgt_clk) disable iff (!rst_n)
    !tgt_en |=> $stable(rst_out));
endmodule

// File: rtl/rlc_status.sv
module rlc_status
  import rlc_pkg::*;
#(
  parameter int                      NUM_LINES = 128,
  parameter logic [MAX_LINES-1:0]    HELD_MASK = '0
) (
  input  logic [NUM_LINES-1:0]          ack,
  output logic [NUM_WORDS*WORD_W-1:0]   status_flat
);
  for (genvar i = 0; i < MAX_LINES; i++) begin : g_bit
    if (i < NUM_LINES) begin : g_live
      assign status_flat[i] = ack[i] ? HELD_MASK[i] : ~HELD_MASK[i];
    end else begin : g_absent
      assign status_flat[i] = HELD_MASK[i];
    end
  end
endmodule

// File: rtl/reset_line_ctrl.sv
module reset_line_ctrl
  import rlc_pkg::*;
#(
  parameter int                    NUM_LINES = 128,
  parameter int                    ADDR_W    = 8,
  parameter logic [MAX_LINES-1:0]  HELD_MASK = 128'h0100_0000_0000_0000_0000_0040_0000_0011
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [WORD_W-1:0]     wr_data,
  output logic [WORD_W-1:0]     rd_data,
  input  logic [NUM_LINES-1:0]  tgt_clk,
  input  logic [NUM_LINES-1:0]  tgt_clk_en,
  output logic [NUM_LINES-1:0]  rst_out
);
  logic [NUM_WORDS*WORD_W-1:0] ctrl_flat;
  logic [NUM_WORDS*WORD_W-1:0] status_flat;
  logic [NUM_LINES-1:0]        ack;

  rlc_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .status_flat (status_flat),
    .rd_data     (rd_data),
    .ctrl_flat   (ctrl_flat)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    rlc_line_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt_clk (tgt_clk[i]),
      .tgt_en  (tgt_clk_en[i]),
      .req     (ctrl_flat[i]),
      .rst_out (rst_out[i]),
      .ack     (ack[i])
    );
  end

  rlc_status #(
    .NUM_LINES (NUM_LINES),
    .HELD_MASK (HELD_MASK)
  ) u_status (
    .ack         (ack),
    .status_flat (status_flat)
  );
endmodule

// File: tb/reset_line_ctrl_bench.sv
`timescale 1ns/1ps
module reset_line_ctrl_bench;
  localparam int LINES = 100;
  localparam logic [127:0] MASK = 128'h0100_0000_0000_0000_0000_0040_0000_0011;
  localparam int NV = 11;
  // {word index, value written}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 32'h0000_0000}, {2'd0, 32'hA5A5_A5A5}, {2'd1, 32'hFFFF_0000},
    {2'd2, 32'h1234_5678}, {2'd3, 32'hFFFF_FFFF}, {2'd3, 32'h0000_0000},
    {2'd1, 32'h0000_0041}, {2'd0, 32'hFFFF_FFFF}, {2'd1, 32'hFFFF_FFFF},
    {2'd2, 32'hFFFF_FFFF}, {2'd3, 32'h0000_000F}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       addr = '0;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      rd_data;
  logic [LINES-1:0] tgt_clk;
  logic [LINES-1:0] tgt_clk_en = '1;
  logic [LINES-1:0] rst_out;

  int errors = 0;
  int checks = 0;
  logic [127:0] shadow = '1;

  always #2 clk = ~clk;
  assign tgt_clk = {LINES{clk}};

  reset_line_ctrl #(.NUM_LINES(LINES), .ADDR_W(8), .HELD_MASK(MASK)) u_reset_line_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tgt_clk(tgt_clk), .tgt_clk_en(tgt_clk_en), .rst_out(rst_out)
  );

  function automatic logic [31:0] exp_ctrl(input int w);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = (w*32+b < LINES) ? shadow[w*32+b] : 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] exp_stat(input int w);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) begin
      if (w*32+b >= LINES) r[b] = MASK[w*32+b];
      else r[b] = shadow[w*32+b] ? MASK[w*32+b] : ~MASK[w*32+b];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(1);
    // R1: reset state
    chk("R1 rst_out", 128'(rst_out), 128'({LINES{1'b1}}));
    for (int w = 0; w < 4; w++) begin
      bus_read(8'(w*4), v);        chk("R1 ctrl", 128'(v), 128'(exp_ctrl(w)));
      bus_read(8'(16 + w*4), v);   chk("R1 status", 128'(v), 128'(exp_stat(w)));
    end

    // Table walk: R2, R4, R7
    for (int i = 0; i < NV; i++) begin
      int w;
      w = int'(VEC[i][33:32]);
      bus_write(8'(w*4), VEC[i][31:0]);
      shadow[w*32 +: 32] = VEC[i][31:0];
      settle(6);
      bus_read(8'(w*4), v);      chk("R2/R7 ctrl readback", 128'(v), 128'(exp_ctrl(w)));
      bus_read(8'(16 + w*4), v); chk("R4/R7 status", 128'(v), 128'(exp_stat(w)));
      chk("R2 rst_out", 128'(rst_out), 128'(shadow[LINES-1:0]));
    end

    // R6: writes to status, unaligned and out-of-range addresses are ignored
    bus_write(8'h10, 32'h0);
    bus_write(8'h01, 32'h0);
    bus_write(8'h24, 32'h0);
    settle(6);
    bus_read(8'h00, v); chk("R6 ctrl untouched", 128'(v), 128'(exp_ctrl(0)));
    chk("R6 rst_out untouched", 128'(rst_out), 128'(shadow[LINES-1:0]));
    bus_read(8'h24, v); chk("R6 unmapped read", 128'(v), 128'(0));
    bus_read(8'h13, v); chk("R6 unaligned read", 128'(v), 128'(0));

    // R3/R8: back-to-back low/high writes, exact flip cycles
    @(negedge clk);
    addr = 8'h00; wr_data = 32'h0; wr_en = 1'b1;
    @(posedge clk);                  // E0
    @(negedge clk);
    addr = 8'h04; wr_data = 32'h0;
    @(posedge clk);                  // E1
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3 rst_out before two edges", 128'(rst_out[0]), 128'(1));
    @(posedge clk);                  // E2
    @(negedge clk);
    chk("R3 rst_out after two edges", 128'(rst_out[0]), 128'(0));
    @(posedge clk);                  // E3
    @(negedge clk);
    bus_read(8'h10, v); chk("R3 status0 held at E3", 128'(v), 128'(exp_stat(0)));
    shadow[31:0] = 32'h0;
    @(posedge clk);                  // E4
    @(negedge clk);
    bus_read(8'h10, v); chk("R3 status0 flips at E4", 128'(v), 128'(exp_stat(0)));
    bus_read(8'h14, v); chk("R8 status1 held at E4", 128'(v), 128'(exp_stat(1)));
    shadow[63:32] = 32'h0;
    @(posedge clk);                  // E5
    @(negedge clk);
    bus_read(8'h14, v); chk("R8 status1 flips at E5", 128'(v), 128'(exp_stat(1)));
    bus_read(8'h00, v); chk("R8 low word kept", 128'(v), 128'(0));
    bus_read(8'h04, v); chk("R8 high word kept", 128'(v), 128'(0));

    // R5: gated target clock on line 5
    bus_write(8'h00, 32'hFFFF_FFFF);
    settle(6);
    tgt_clk_en[5] = 1'b0;
    bus_write(8'h00, 32'hFFFF_FFDF);
    settle(10);
    chk("R5 rst_out held while gated", 128'(rst_out[5]), 128'(1));
    bus_read(8'h10, v); chk("R5 status held while gated", 128'(v), 128'(32'h0000_0011));
    bus_read(8'h00, v); chk("R5 ctrl stored while gated", 128'(v), 128'(32'hFFFF_FFDF));
    tgt_clk_en[5] = 1'b1;
    settle(6);
    chk("R5 rst_out released after enable", 128'(rst_out[5]), 128'(0));
    bus_read(8'h10, v); chk("R5 status released after enable", 128'(v), 128'(32'h0000_0031));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule